// File: doc/BRIEF.md
# Dual-Clock FIFO with Unified or Split Configuration

This block is a word buffer that crosses from a write clock to a read clock. It runs in one of two configurations. In unified mode it is a single queue of `DEPTH` entries. In split mode it is two independent queues of `DEPTH/2` entries each. A two-bit control code does two jobs. It clears one queue, or it names the queue that the write and read strobes and the three status flags refer to. The strobes and the flags are all active low.

Each queue keeps its own binary and Gray-coded pointers in each clock domain. A two-flop synchroniser carries each pointer across to the other domain. After a queue is cleared, the first write request to it is consumed without storing anything. That request primes the queue, and stored data begins with the next request. The read output is not a register. It shows the storage slot that was read last. A later read moves it, and the write that fills a queue also rewrites that slot.

Top module: `dual_mode_fifo`

## Requirements
- R1: Control code `rs_code` works as follows. 2'b00 clears queue 0, and in unified mode it also clears queue 1. 2'b01 clears queue 1. 2'b10 selects queue 0. 2'b11 selects queue 1 in split mode and the single queue in unified mode. A clear code held for at least four cycles of both clocks leaves the cleared queue empty and unprimed.
- R2: While the selected queue is empty, `empty_n` is 0. While it is not full, `full_n` is 1. Below the threshold of R7, `half_n` is 1.
- R3: Words come out in the order in which they were stored.
- R4: After a queue is cleared, its first accepted write request stores nothing. Each later request stores one word.
- R5: A queue holds 16 words in unified mode and 8 words per queue in split mode (for the default `DEPTH` of 16). `full_n` goes to 0 when the queue reaches that count.
- R6: A write to a full queue is ignored. A read from an empty queue is ignored and leaves `rd_data` unchanged.
- R7: `half_n` is 0 while the stored count is at least half the capacity of the queue: 8 in unified mode and 4 in split mode.
- R8: Clearing one queue in split mode leaves the contents and flags of the other queue unchanged.
- R9: The configuration is taken from `split_mode` (1 = split) only while code 2'b00 is applied. At any other time the input has no effect.
- R10: `rd_data` holds the last word read until the next read. The exception is the write that fills the queue read last, which replaces the value shown.
- R11: While a clear code (2'b00 or 2'b01) is applied, no write and no read takes effect on any queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset of all state |
| split_mode | input | 1 | Configuration request, sampled under code 2'b00 |
| rs_code | input | 2 | Clear/select code |
| wr_en_n | input | 1 | Active-low write strobe |
| wr_data | input | DATA_W | Write word |
| rd_en_n | input | 1 | Active-low read strobe |
| rd_data | output | DATA_W | Word in the last slot read |
| empty_n | output | 1 | Low when the selected queue is empty |
| full_n | output | 1 | Low when the selected queue is full |
| half_n | output | 1 | Low at or above the half threshold |

## Verification
The hardest case to reach is the fill-time rewrite of the slot last read. The read pointer must first be moved away from slot zero by a short write-then-read run. After that, exactly enough writes must be made to fill the queue, with `rd_data` compared on every one of them. The first write after each clear must be swallowed before any of this can be set up. Because the flags lag behind the synchroniser, the stimulus idles for a few cycles between write bursts and read bursts. It then compares the flags with a queue model that knows about priming, capacity per mode and the independence of the two queues.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    typedef enum logic [1:0] {
        RS_CLR_LO = 2'b00,
        RS_CLR_HI = 2'b01,
        RS_SEL_LO = 2'b10,
        RS_SEL_HI = 2'b11
    } rs_code_e;
endpackage

// File: rtl/sfifo_sync2.sv
module sfifo_sync2 #(
    parameter int unsigned W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.s1 = clr ? '0 : d;
        st_d.s2 = clr ? '0 : st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/sfifo_wr_ctl.sv
module sfifo_wr_ctl #(
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned HALF_ID = 0,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          split,
    input  logic          req,
    input  logic [PW-1:0] rgray_s,
    output logic [PW-1:0] wgray,
    output logic [AW-1:0] waddr,
    output logic          fire,
    output logic          full,
    output logic          half
);
    typedef struct packed {
        logic [PW-1:0] bin;
        logic          armed;
    } st_t;

    st_t           st_d, st_q;
    logic [PW-1:0] rbin;
    logic [PW-1:0] count;
    logic [PW-1:0] cap;

    always_comb begin
        rbin[PW-1] = rgray_s[PW-1];
        for (int k = PW - 2; k >= 0; k--) rbin[k] = rbin[k+1] ^ rgray_s[k];
        cap   = split ? PW'(DEPTH / 2) : PW'(DEPTH);
        count = st_q.bin - rbin;
        full  = (count >= cap);
        half  = (count >= (cap >> 1));
        fire  = req && st_q.armed && !full && !clr;
        st_d  = st_q;
        if (clr)                     st_d = '0;
        else if (req && !st_q.armed) st_d.armed = 1'b1;
        else if (fire)               st_d.bin = st_q.bin + PW'(1);
        wgray = st_q.bin ^ (st_q.bin >> 1);
        waddr = split ? {1'(HALF_ID), st_q.bin[AW-2:0]} : st_q.bin[AW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: the stored count never goes above the capacity of the mode
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n || clr)
        count <= cap);
    // R4: a request while unprimed primes the queue and stores nothing
    p_swallow_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !st_q.armed && !clr) |=> ($stable(st_q.bin) && st_q.armed));
    // R1: a clear code returns the pointer to zero and unprimes the queue
    p_clear_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.bin == '0 && !st_q.armed));
endmodule

// File: rtl/sfifo_rd_ctl.sv
module sfifo_rd_ctl #(
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned HALF_ID = 0,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          split,
    input  logic          req,
    input  logic [PW-1:0] wgray_s,
    output logic [PW-1:0] rgray,
    output logic [AW-1:0] raddr,
    output logic          fire,
    output logic          empty
);
    typedef struct packed {
        logic [PW-1:0] bin;
    } st_t;

    st_t           st_d, st_q;
    logic [PW-1:0] wbin;
    logic [PW-1:0] cap;

    always_comb begin
        wbin[PW-1] = wgray_s[PW-1];
        for (int k = PW - 2; k >= 0; k--) wbin[k] = wbin[k+1] ^ wgray_s[k];
        cap   = split ? PW'(DEPTH / 2) : PW'(DEPTH);
        empty = (st_q.bin == wbin);
        fire  = req && !empty && !clr;
        st_d  = st_q;
        if (clr)       st_d = '0;
        else if (fire) st_d.bin = st_q.bin + PW'(1);
        rgray = st_q.bin ^ (st_q.bin >> 1);
        raddr = split ? {1'(HALF_ID), st_q.bin[AW-2:0]} : st_q.bin[AW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: the read pointer never passes the synchronised write pointer
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n || clr)
        (wbin - st_q.bin) <= cap);
endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
    import sfifo_pkg::*;
#(
    parameter int unsigned DATA_W = 72,
    parameter int unsigned DEPTH  = 16
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              split_mode,
    input  logic [1:0]        rs_code,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              full_n,
    output logic              half_n
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned PW = AW + 1;

    typedef struct packed {
        logic split;
    } wdom_t;

    typedef struct packed {
        logic          split;
        logic [AW-1:0] addr;
    } rdom_t;

    wdom_t             wdom_d, wdom_q;
    rdom_t             rdom_d, rdom_q;
    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    logic [1:0]         clr;
    logic [1:0]         wreq, rreq, wfire, rfire, full, half, empty;
    logic [1:0][PW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic [1:0][AW-1:0] waddr, raddr;
    logic               sel_w, sel_r, access;

    always_comb begin
        clr[0] = (rs_code == RS_CLR_LO);
        clr[1] = (rs_code == RS_CLR_HI) || ((rs_code == RS_CLR_LO) && !split_mode);
        access = rs_code[1];
        sel_w  = wdom_q.split & rs_code[0];
        sel_r  = rdom_q.split & rs_code[0];
        for (int i = 0; i < 2; i++) begin
            wreq[i] = access && !wr_en_n && (sel_w == 1'(i));
            rreq[i] = access && !rd_en_n && (sel_r == 1'(i));
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_q
        sfifo_wr_ctl #(.DEPTH(DEPTH), .HALF_ID(g)) u_wr (
            .clk(wr_clk), .rst_n(rst_n), .clr(clr[g]), .split(wdom_q.split),
            .req(wreq[g]), .rgray_s(rgray_s[g]), .wgray(wgray[g]),
            .waddr(waddr[g]), .fire(wfire[g]), .full(full[g]), .half(half[g]));
        sfifo_rd_ctl #(.DEPTH(DEPTH), .HALF_ID(g)) u_rd (
            .clk(rd_clk), .rst_n(rst_n), .clr(clr[g]), .split(rdom_q.split),
            .req(rreq[g]), .wgray_s(wgray_s[g]), .rgray(rgray[g]),
            .raddr(raddr[g]), .fire(rfire[g]), .empty(empty[g]));
        sfifo_sync2 #(.W(PW)) u_r2w (
            .clk(wr_clk), .rst_n(rst_n), .clr(clr[g]), .d(rgray[g]), .q(rgray_s[g]));
        sfifo_sync2 #(.W(PW)) u_w2r (
            .clk(rd_clk), .rst_n(rst_n), .clr(clr[g]), .d(wgray[g]), .q(wgray_s[g]));
    end

    // write domain: mode capture and storage
    always_comb begin
        wdom_d = wdom_q;
        if (rs_code == RS_CLR_LO) wdom_d.split = split_mode;
        mem_d = mem_q;
        if (|wfire) mem_d[wfire[1] ? waddr[1] : waddr[0]] = wr_data;
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) wdom_q <= '0;
        else        wdom_q <= wdom_d;
    end

    always_ff @(posedge wr_clk) mem_q <= mem_d;

    // read domain: mode capture and last-read slot
    always_comb begin
        rdom_d = rdom_q;
        if (rs_code == RS_CLR_LO) rdom_d.split = split_mode;
        if (|rfire) rdom_d.addr = rfire[1] ? raddr[1] : raddr[0];
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) rdom_q <= '0;
        else        rdom_q <= rdom_d;
    end

    assign rd_data = mem_q[rdom_q.addr];
    assign full_n  = ~full[sel_w];
    assign half_n  = ~half[sel_w];
    assign empty_n = ~empty[sel_r];

    // R9: the configuration changes only under the clear-0 code
    p_mode_hold_r9: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (rs_code != RS_CLR_LO) |=> $stable(wdom_q.split));
    // R11: no write lands while a clear code is applied
    p_no_write_in_clear_r11: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !access |-> (wfire == 2'b00));
    // R11: no read lands while a clear code is applied
    p_no_read_in_clear_r11: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !access |-> (rfire == 2'b00));
endmodule

// File: tb/tb_dual_mode_fifo.sv
module tb_dual_mode_fifo;
    localparam int DW = 72;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          split_mode = 1'b0;
    logic [1:0]    rs_code = 2'b00;
    logic          wr_en_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en_n = 1'b1;
    logic [DW-1:0] rd_data;
    logic          empty_n, full_n, half_n;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    logic [DW-1:0] mq0[$];
    logic [DW-1:0] mq1[$];
    bit            armed[2];
    bit            split_m   = 1'b0;
    logic [DW-1:0] exp_out   = '0;
    bit            out_valid = 1'b0;
    int            last_h    = 0;

    always #2 clk = ~clk;

    dual_mode_fifo dut (
        .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .split_mode(split_mode),
        .rs_code(rs_code), .wr_en_n(wr_en_n), .wr_data(wr_data),
        .rd_en_n(rd_en_n), .rd_data(rd_data), .empty_n(empty_n),
        .full_n(full_n), .half_n(half_n));

    function automatic logic [DW-1:0] word(input int k);
        return {8'(k), 32'(k * 32'h9E3779B1), 32'(~k)};
    endfunction

    function automatic int cur_h();
        return split_m ? int'(rs_code[0]) : 0;
    endfunction

    function automatic int qsize(input int h);
        return (h == 0) ? mq0.size() : mq1.size();
    endfunction

    function automatic int cap();
        return split_m ? 8 : 16;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clear_half(input int h);
        if (h == 0) mq0.delete(); else mq1.delete();
        armed[h] = 1'b0;
        if (last_h == h) out_valid = 1'b0;
    endtask

    // R1 R9: apply a clear code for four cycles and update the model
    task automatic reset_code(input logic [1:0] code);
        @(negedge clk);
        rs_code = code;
        if (code == 2'b00) begin
            split_m = split_mode;
            clear_half(0);
            if (!split_mode) clear_half(1);
            out_valid = 1'b0;
        end else begin
            clear_half(1);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic select(input logic [1:0] code);
        @(negedge clk);
        rs_code = code;
    endtask

    task automatic check_flags(input string tag);
        int h = cur_h();
        int s = qsize(h);
        chk(empty_n == (s > 0), {tag, " empty_n"}, DW'(empty_n), DW'(s > 0));
        chk(full_n == (s < cap()), {tag, " full_n"}, DW'(full_n), DW'(s < cap()));
        chk(half_n == (s < cap() / 2), {tag, " half_n"}, DW'(half_n), DW'(s < cap() / 2));
        if (out_valid) chk(rd_data == exp_out, {tag, " rd_data hold R10"}, rd_data, exp_out);
    endtask

    task automatic settle(input string tag);
        repeat (4) @(negedge clk);
        check_flags(tag);
    endtask

    task automatic do_write(input logic [DW-1:0] d, input string tag);
        int h = cur_h();
        @(negedge clk);
        wr_en_n = 1'b0;
        wr_data = d;
        if (rs_code[1]) begin
            if (!armed[h]) armed[h] = 1'b1;
            else if (qsize(h) < cap()) begin
                if (h == 0) mq0.push_back(d); else mq1.push_back(d);
                if (qsize(h) == cap() && out_valid && last_h == h) exp_out = d;
            end
        end
        @(negedge clk);
        wr_en_n = 1'b1;
        if (rs_code[1]) begin
            chk(full_n == (qsize(h) < cap()), {tag, " full_n R5"}, DW'(full_n), DW'(qsize(h) < cap()));
            chk(half_n == (qsize(h) < cap() / 2), {tag, " half_n R7"}, DW'(half_n), DW'(qsize(h) < cap() / 2));
        end
        if (out_valid) chk(rd_data == exp_out, {tag, " rd_data R10"}, rd_data, exp_out);
    endtask

    task automatic do_read(input string tag);
        int h = cur_h();
        @(negedge clk);
        rd_en_n = 1'b0;
        if (rs_code[1] && qsize(h) > 0) begin
            exp_out = (h == 0) ? mq0.pop_front() : mq1.pop_front();
            out_valid = 1'b1;
            last_h = h;
        end
        @(negedge clk);
        rd_en_n = 1'b1;
        if (out_valid) chk(rd_data == exp_out, {tag, " order R3"}, rd_data, exp_out);
        if (rs_code[1])
            chk(empty_n == (qsize(h) > 0), {tag, " empty_n R6"}, DW'(empty_n), DW'(qsize(h) > 0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        reset_code(2'b00);
        select(2'b10);
        settle("R2 after reset");
        select(2'b11);
        settle("R1 unified select 11");
        select(2'b10);

        // R4: first request after clear is swallowed
        do_write(word(100), "R4 prime");
        settle("R4 empty after prime");
        for (int i = 0; i < 3; i++) do_write(word(i), "R4 store");
        settle("R4 after three");
        for (int i = 0; i < 3; i++) do_read("R3 short");
        settle("R3 drained");

        // R5 R7 R10: fill unified queue; filling write rewrites last-read slot
        for (int i = 0; i < 17; i++) do_write(word(10 + i), "R5 unified fill");
        settle("R6 full held");
        for (int i = 0; i < 16; i++) do_read("R3 unified drain");
        do_read("R6 read when empty");
        settle("R6 empty");

        // R11: code 01 in unified mode blocks access
        reset_code(2'b01);
        do_write(word(200), "R11 write under clear");
        do_read("R11 read under clear");
        select(2'b10);
        settle("R11 nothing stored");

        // split configuration
        split_mode = 1'b1;
        reset_code(2'b00);
        reset_code(2'b01);
        select(2'b10);
        settle("R1 split q0 empty");
        do_write(word(300), "R4 q0 prime");
        for (int i = 0; i < 5; i++) do_write(word(40 + i), "R7 q0 write");
        select(2'b11);
        settle("R8 q1 empty");
        do_write(word(301), "R4 q1 prime");
        for (int i = 0; i < 9; i++) do_write(word(60 + i), "R5 q1 fill");
        select(2'b10);
        settle("R8 q0 flags");
        reset_code(2'b01);
        select(2'b10);
        settle("R8 q0 kept");
        for (int i = 0; i < 5; i++) do_read("R8 q0 drain");
        select(2'b11);
        settle("R8 q1 cleared");

        // R9: mode input ignored outside code 00
        split_mode = 1'b0;
        select(2'b10);
        for (int i = 0; i < 9; i++) do_write(word(80 + i), "R9 split kept");
        settle("R9 q0 full at 8");
        for (int i = 0; i < 8; i++) do_read("R9 drain");
        settle("R9 end");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule